// File: doc/BRIEF.md
# Predicated Instruction Window Sequencer

This block sits beside an instruction issue stage and governs a short run of predicated instructions. An if-then style instruction opens the run with a start pulse. The pulse carries a four-bit condition code, the total slot count (one to four) and the number of leading "then" slots. Every slot after the leading "then" slots is an "else" slot.

While the run is open, the block tells the issue stage whether the instruction now at the head of issue may execute. A "then" slot evaluates the base condition against the N, Z, C and V flags present in the current cycle. An "else" slot evaluates the inverse of that condition. Each issue pulse consumes one slot, and the window closes once the last slot has been consumed. Outside a window every instruction executes. A start pulse that arrives while a window is open is refused, and a one-cycle error indication is raised.

Top module: `pred_window_seq`

## Requirements
- R1: After reset, `win_active` is 0, `exec_ok` is 1 and `start_err` is 0.
- R2: A `start` pulse while no window is open makes `win_active` 1 from the next cycle. The window then holds `start_len_m1`+1 slots, the base condition `start_cond`, and `start_then_m1`+1 leading then slots.
- R3: Each cycle with `issue` high while the window is open consumes exactly one slot. After the issue of the last slot, `win_active` is 0 in the next cycle.
- R4: Slot k (counting from 0) is a then slot when k <= `start_then_m1` and an else slot otherwise, so slot 0 is always a then slot. A then slot's `exec_ok` is the base condition. An else slot's `exec_ok` is the inverse, which for the always codes means the else slot never executes.
- R5: The condition codes are: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0, 8 C=1 and Z=0, 9 C=0 or Z=1, 10 N=V, 11 N!=V, 12 Z=0 and N=V, 13 Z=1 or N!=V, 14 and 15 always true.
- R6: While a window is open, `exec_ok` follows the flag inputs of the current cycle without delay. A flag change between slots therefore changes the outcome of the later slots.
- R7: While no window is open, `exec_ok` is 1 whatever the flags are.
- R8: A `start` while a window is open is ignored. The open window keeps its condition, slot count and position. `start_err` is 1 for exactly the next cycle.
- R9: `issue` while no window is open has no effect. When `start` and `issue` are both high while no window is open, the window opens with its full slot count.
- R10: When `start` arrives in the same cycle as the issue of the last slot, the window closes and the start is refused with `start_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Open-window request pulse |
| start_cond | input | 4 | Base condition code |
| start_len_m1 | input | 2 | Slot count minus one |
| start_then_m1 | input | 2 | Then-slot count minus one |
| issue | input | 1 | Instruction issued this cycle; consumes a slot |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| win_active | output | 1 | A predicated window is open |
| exec_ok | output | 1 | Current instruction may execute |
| start_err | output | 1 | Start was refused in the previous cycle |

## Verification
A start request and the issue of the last slot can fall in the same cycle. In that cycle the window is still open, yet it is about to close. The bench provokes this by opening a one-slot window and then raising `start` and `issue` together. It expects the window to close, `start_err` to pulse, and no new window to follow. The bench also pairs `start` with `issue` while no window is open, and checks by counting issues to closure that no slot was consumed.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [3:0] {
    CC_ZSET  = 4'd0,
    CC_ZCLR  = 4'd1,
    CC_CSET  = 4'd2,
    CC_CCLR  = 4'd3,
    CC_NSET  = 4'd4,
    CC_NCLR  = 4'd5,
    CC_VSET  = 4'd6,
    CC_VCLR  = 4'd7,
    CC_UHI   = 4'd8,
    CC_ULS   = 4'd9,
    CC_SGE   = 4'd10,
    CC_SLT   = 4'd11,
    CC_SGT   = 4'd12,
    CC_SLE   = 4'd13,
    CC_ALW0  = 4'd14,
    CC_ALW1  = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/pws_cond_eval.sv
module pws_cond_eval
  import pws_pkg::*;
(
  input  cond_e  cond,
  input  flags_t fl,
  output logic   holds
);

  logic sgn_eq;

  always_comb begin
    sgn_eq = (fl.n == fl.v);
    unique case (cond)
      CC_ZSET: holds = fl.z;
      CC_ZCLR: holds = ~fl.z;
      CC_CSET: holds = fl.c;
      CC_CCLR: holds = ~fl.c;
      CC_NSET: holds = fl.n;
      CC_NCLR: holds = ~fl.n;
      CC_VSET: holds = fl.v;
      CC_VCLR: holds = ~fl.v;
      CC_UHI:  holds = fl.c & ~fl.z;
      CC_ULS:  holds = ~fl.c | fl.z;
      CC_SGE:  holds = sgn_eq;
      CC_SLT:  holds = ~sgn_eq;
      CC_SGT:  holds = ~fl.z & sgn_eq;
      CC_SLE:  holds = fl.z | ~sgn_eq;
      default: holds = 1'b1;
    endcase
  end

endmodule

// File: rtl/pws_slot_ctrl.sv
module pws_slot_ctrl
  import pws_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic              issue,
  input  cond_e             cond_in,
  input  logic [SLOT_W-1:0] len_m1,
  input  logic [SLOT_W-1:0] then_m1,
  output logic              active,
  output cond_e             cond_q,
  output logic              slot_else
);

  logic              active_q, active_d;
  logic [SLOT_W-1:0] idx_q, idx_d;
  logic [SLOT_W-1:0] last_q, last_d;
  logic [SLOT_W-1:0] thenl_q, thenl_d;
  cond_e             cond_d;
  logic              at_last;
  logic              load_en, step_en;

  assign at_last = (idx_q == last_q);
  assign load_en = open & ~active_q;
  assign step_en = issue & active_q;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    last_d   = last_q;
    thenl_d  = thenl_q;
    cond_d   = cond_q;
    if (load_en) begin
      active_d = 1'b1;
      idx_d    = '0;
      last_d   = len_m1;
      thenl_d  = then_m1;
      cond_d   = cond_in;
    end else if (step_en) begin
      if (at_last) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d    = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
      thenl_q  <= '0;
      cond_q   <= CC_ALW0;
    end else if (load_en | step_en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
      thenl_q  <= thenl_d;
      cond_q   <= cond_d;
    end
  end

  assign active    = active_q;
  assign slot_else = (idx_q > thenl_q);

  AST_OPEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    open && !active_q |=> active_q && idx_q == '0);  // R2
  AST_CLOSE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && issue && at_last |=> !active_q);  // R3
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && issue && !at_last |=> active_q && idx_q == SLOT_W'($past(idx_q) + 1'b1));  // R3
  AST_COND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> $stable(cond_q) && $stable(last_q));  // R8

endmodule

// File: rtl/pred_window_seq.sv
module pred_window_seq
  import pws_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [COND_W-1:0] start_cond,
  input  logic [SLOT_W-1:0] start_len_m1,
  input  logic [SLOT_W-1:0] start_then_m1,
  input  logic              issue,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              win_active,
  output logic              exec_ok,
  output logic              start_err
);

  cond_e  cond_cur;
  flags_t fl;
  logic   cond_true;
  logic   slot_else;
  logic   refuse;
  logic   err_q, err_d;

  assign fl = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  pws_slot_ctrl #(.SLOT_W(SLOT_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .open      (start),
    .issue     (issue),
    .cond_in   (cond_e'(start_cond[3:0])),
    .len_m1    (start_len_m1),
    .then_m1   (start_then_m1),
    .active    (win_active),
    .cond_q    (cond_cur),
    .slot_else (slot_else)
  );

  pws_cond_eval u_eval (
    .cond  (cond_cur),
    .fl    (fl),
    .holds (cond_true)
  );

  assign refuse = start & win_active;

  always_comb begin
    err_d = refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign start_err = err_q;
  assign exec_ok   = win_active ? (cond_true ^ slot_else) : 1'b1;

  AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    start && win_active |=> start_err);  // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> $past(start && win_active));  // R8
  AST_IDLE_ISSUE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !win_active && issue && !start |=> !win_active);  // R9

endmodule

// File: tb/sim_pred_window_seq.sv
module sim_pred_window_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, issue;
  logic [3:0] start_cond;
  logic [1:0] start_len_m1, start_then_m1;
  logic       flag_n, flag_z, flag_c, flag_v;
  logic       win_active, exec_ok, start_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pred_window_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cond(start_cond),
    .start_len_m1(start_len_m1), .start_then_m1(start_then_m1), .issue(issue),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .win_active(win_active), .exec_ok(exec_ok), .start_err(start_err)
  );

  function automatic logic ref_cond(input int code, input logic n, z, c, v);
    case (code)
      0: return z;        1: return !z;
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return c && !z;  9: return !c || z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    start = 1'b0;
    issue = 1'b0;
    #1;
  endtask

  task automatic set_flags(input logic [3:0] f);
    {flag_n, flag_z, flag_c, flag_v} = f;
    #1;
  endtask

  task automatic open_win(input int code, input int len_m1, input int then_m1);
    start = 1'b1;
    start_cond = 4'(code);
    start_len_m1 = 2'(len_m1);
    start_then_m1 = 2'(then_m1);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 win_active", win_active, 1'b0);
    chk("R1 exec_ok", exec_ok, 1'b1);
    chk("R1 start_err", start_err, 1'b0);
  endtask

  task automatic t_cond_table();
    for (int code = 0; code < 16; code++) begin
      open_win(code, 0, 0);
      chk("R2 opened", win_active, 1'b1);
      for (int f = 0; f < 16; f++) begin
        set_flags(4'(f));
        chk($sformatf("R5 R6 code=%0d flags=%0h", code, f), exec_ok,
            ref_cond(code, flag_n, flag_z, flag_c, flag_v));
      end
      issue = 1'b1;
      tick();
      chk("R3 closed after single slot", win_active, 1'b0);
    end
  endtask

  task automatic t_pattern();
    logic exp [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    set_flags(4'b0100);
    open_win(0, 3, 1);
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R4 then/else slot %0d", k), exec_ok, exp[k]);
      chk("R3 still open", win_active, 1'b1);
      issue = 1'b1;
      tick();
    end
    chk("R3 closed after four", win_active, 1'b0);
    open_win(1, 1, 3);
    chk("R4 clamp slot0 then", exec_ok, 1'b0);
    issue = 1'b1; tick();
    chk("R4 clamp slot1 then", exec_ok, 1'b0);
    issue = 1'b1; tick();
    chk("R3 closed after two", win_active, 1'b0);
    open_win(14, 1, 0);
    chk("R4 always then", exec_ok, 1'b1);
    issue = 1'b1; tick();
    chk("R4 always else never", exec_ok, 1'b0);
    issue = 1'b1; tick();
    chk("R3 closed", win_active, 1'b0);
  endtask

  task automatic t_live_flags();
    set_flags(4'b0000);
    open_win(1, 2, 2);
    chk("R6 slot0 z=0", exec_ok, 1'b1);
    issue = 1'b1; tick();
    set_flags(4'b0100);
    chk("R6 slot1 z=1", exec_ok, 1'b0);
    issue = 1'b1; tick();
    set_flags(4'b0000);
    chk("R6 slot2 z=0", exec_ok, 1'b1);
    issue = 1'b1; tick();
    chk("R3 closed", win_active, 1'b0);
  endtask

  task automatic t_idle();
    for (int f = 0; f < 16; f += 5) begin
      set_flags(4'(f));
      chk("R7 idle exec_ok", exec_ok, 1'b1);
    end
  endtask

  task automatic t_refuse();
    set_flags(4'b0100);
    open_win(0, 2, 2);
    issue = 1'b1; tick();
    start = 1'b1; start_cond = 4'd1; start_len_m1 = 2'd3; start_then_m1 = 2'd3;
    tick();
    chk("R8 start_err pulse", start_err, 1'b1);
    chk("R8 window kept", win_active, 1'b1);
    chk("R8 cond kept", exec_ok, 1'b1);
    tick();
    chk("R8 start_err one cycle", start_err, 1'b0);
    issue = 1'b1; tick();
    chk("R8 position kept", win_active, 1'b1);
    issue = 1'b1; tick();
    chk("R8 length kept", win_active, 1'b0);
  endtask

  task automatic t_issue_idle();
    issue = 1'b1; tick();
    chk("R9 issue idle no window", win_active, 1'b0);
    chk("R9 issue idle exec_ok", exec_ok, 1'b1);
    start = 1'b1; issue = 1'b1;
    start_cond = 4'd0; start_len_m1 = 2'd1; start_then_m1 = 2'd1;
    tick();
    chk("R9 start+issue opens", win_active, 1'b1);
    chk("R9 no start_err", start_err, 1'b0);
    issue = 1'b1; tick();
    chk("R9 full count slot1", win_active, 1'b1);
    issue = 1'b1; tick();
    chk("R9 closes after full count", win_active, 1'b0);
  endtask

  task automatic t_collide();
    open_win(0, 0, 0);
    start = 1'b1; issue = 1'b1;
    start_cond = 4'd1; start_len_m1 = 2'd2; start_then_m1 = 2'd0;
    tick();
    chk("R10 window closed", win_active, 1'b0);
    chk("R10 start refused", start_err, 1'b1);
    tick();
    chk("R10 no late window", win_active, 1'b0);
    chk("R10 err cleared", start_err, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0; issue = 1'b0;
    start_cond = '0; start_len_m1 = '0; start_then_m1 = '0;
    {flag_n, flag_z, flag_c, flag_v} = 4'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    t_reset();
    t_cond_table();
    t_pattern();
    t_live_flags();
    t_idle();
    t_refuse();
    t_issue_idle();
    t_collide();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule